// File: doc/BRIEF.md
# Slow-Domain Write Gate

This block sits between a fast register bus and a slow always-on timekeeping domain. It decides which bus writes may travel on to the slow registers and which are dropped. A write passes only when the slow domain can take it. On the keyed build it must also have been armed by a key written just before it. The forwarded write goes out unchanged on a separate strobe, address and data. The receiving registers live outside this block.

Two status bits tell software when it may write. The ready bit is high while the gate is idle. It drops for a fixed window after each forwarded write, which stands in for the transfer into the slow clock. The unlocked bit is high once the key has been accepted. It clears again after one forwarded write, so each write needs its own key. A build parameter selects a ready-only variant that has no key register at all. Both status bits always return high within a bounded number of cycles, so a polling loop with a finite retry count ends.

Top module: `rtc_write_gate`

## Requirements
- R1: After reset, `wr_ready` is 1, `wr_unlocked` is 0 and `fwd_we` is 0.
- R2: In keyed mode, a write to offset `UNLOCK_OFS` (default 0x3C) whose low 16 data bits equal `KEY` (default 0xA55A) sets `wr_unlocked` on the next cycle. The upper data bits are ignored. Key writes are accepted whether or not `wr_ready` is high, are never forwarded and do not start a busy window.
- R3: A key write whose low 16 bits differ from `KEY` leaves `wr_unlocked` at 0, and clears it if it was set.
- R4: Any other write raises `fwd_we` in the same cycle, with `fwd_addr`/`fwd_data` equal to the bus address and data, if and only if `wr_ready` and `wr_unlocked` are both 1.
- R5: In keyed mode, a forwarded write clears `wr_unlocked` on the next cycle.
- R6: After a forwarded write, `wr_ready` is 0 for exactly `BUSY_CYC` cycles and then returns to 1. `wr_ready` never falls without a forwarded write.
- R7: A write made while `wr_ready` is 0 or while locked gives no strobe. It leaves `wr_unlocked` unchanged and does not restart or lengthen the busy window.
- R8: In ready-only mode (`MODE = GATE_READY_ONLY`), `wr_unlocked` reads 1 and every write, at any offset, is forwarded when `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Bus write request, one cycle per write |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| fwd_we | output | 1 | Write strobe passed on to the slow registers |
| fwd_addr | output | ADDR_W | Offset passed on with the strobe |
| fwd_data | output | DATA_W | Data passed on with the strobe |
| wr_ready | output | 1 | High when a write may be made (idle) |
| wr_unlocked | output | 1 | High when the key has armed one write |

## Verification
The assertions check several rules on every cycle. A strobe is raised only while idle. The ready bit falls only after a strobe, and the busy count stays in range. A good key opens the lock, a bad key or a strobe closes it, and any other write holds it. A dropped write leaves the ready bit high. Only the bench scenarios can show the exact length of the busy window seen at the ports. They also show that a key is accepted mid-window, that a write dropped mid-window does not extend it, and that the upper key bits are ignored. The ready-only build is checked there against the keyed one under the same stimulus.

// File: rtl/rtc_wgate_pkg.sv
// Package: shared constants and build options for the slow-domain write gate.
// Assumes: the key occupies the low KEY_W bits of a bus write.
package rtc_wgate_pkg;
    localparam int unsigned KEY_W = 16;
    localparam logic [KEY_W-1:0] DEFAULT_KEY = 16'hA55A;

    // Build variant: keyed needs an unlock before each write, ready-only does not.
    typedef enum logic {
        GATE_READY_ONLY = 1'b0,
        GATE_KEYED      = 1'b1
    } gate_mode_e;
endpackage

// File: rtl/rtc_wgate_keylock.sv
// Module: key register and one-shot lock for the keyed variant.
// Does: decodes writes to the key offset, compares the key, holds the
// unlocked bit until one write has been committed.
// Assumes: commit is never high in the same cycle as a key write.
module rtc_wgate_keylock
    import rtc_wgate_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 6,
    parameter logic [ADDR_W-1:0]  UNLOCK_OFS = 6'h3C,
    parameter logic [KEY_W-1:0]   KEY        = DEFAULT_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  key_data,
    input  logic              commit,
    output logic              key_sel,
    output logic              unlocked
);
    logic key_match;

    // Decode a write aimed at the key register and compare its value.
    always_comb begin
        key_sel   = wr_valid && (wr_addr == UNLOCK_OFS);
        key_match = (key_data == KEY);
    end

    // Lock state: a key write sets or clears it, a committed write consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (key_sel) begin
            unlocked <= key_match;
        end else if (commit) begin
            unlocked <= 1'b0;
        end
    end

    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == UNLOCK_OFS && key_data == KEY) |=> unlocked);

    assert_bad_key_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == UNLOCK_OFS && key_data != KEY) |=> !unlocked);

    assert_commit_relocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !unlocked);

    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !(wr_valid && wr_addr == UNLOCK_OFS)) |=> $stable(unlocked));
endmodule

// File: rtl/rtc_wgate_busy.sv
// Module: busy window timer modelling the transfer into the slow domain.
// Does: holds ready low for BUSY_CYC cycles after each committed write.
// Assumes: BUSY_CYC >= 1; commit only arrives while ready is high.
module rtc_wgate_busy #(
    parameter int unsigned BUSY_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    output logic ready
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC);

    logic [CNT_W-1:0] cnt;

    // Count down the remaining busy cycles; reload on each committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (commit) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Ready whenever no transfer is in flight.
    always_comb ready = (cnt == '0);

    assert_commit_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cnt == '0));

    assert_busy_needs_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(commit));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
endmodule

// File: rtl/rtc_write_gate.sv
// Module: top of the slow-domain write gate.
// Does: forwards a bus write only when the busy timer is idle and, in keyed
// mode, the lock has been opened by a key write. The keyed variant and the
// busy timer are chosen by parameters.
// Assumes: one write per wr_valid cycle; the receiving registers sit downstream.
module rtc_write_gate
    import rtc_wgate_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 6,
    parameter int unsigned        DATA_W     = 32,
    parameter logic [ADDR_W-1:0]  UNLOCK_OFS = 6'h3C,
    parameter logic [KEY_W-1:0]   KEY        = DEFAULT_KEY,
    parameter int unsigned        BUSY_CYC   = 3,
    parameter gate_mode_e         MODE       = GATE_KEYED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fwd_we,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic              wr_ready,
    output logic              wr_unlocked
);
    logic key_sel;
    logic unlocked;
    logic ready;
    logic commit;

    // Lock: the key register in keyed mode, permanently open otherwise.
    generate
        if (MODE == GATE_KEYED) begin : g_keyed
            rtc_wgate_keylock #(
                .ADDR_W     (ADDR_W),
                .UNLOCK_OFS (UNLOCK_OFS),
                .KEY        (KEY)
            ) u_lock (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_valid (wr_valid),
                .wr_addr  (wr_addr),
                .key_data (wr_data[KEY_W-1:0]),
                .commit   (commit),
                .key_sel  (key_sel),
                .unlocked (unlocked)
            );

            assert_key_not_forwarded_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && wr_addr == UNLOCK_OFS) |-> !fwd_we);
        end else begin : g_open
            assign key_sel  = 1'b0;
            assign unlocked = 1'b1;
        end
    endgenerate

    // Busy window: a timer when transfers take time, always ready otherwise.
    generate
        if (BUSY_CYC > 0) begin : g_busy
            rtc_wgate_busy #(
                .BUSY_CYC (BUSY_CYC)
            ) u_busy (
                .clk    (clk),
                .rst_n  (rst_n),
                .commit (commit),
                .ready  (ready)
            );
        end else begin : g_nobusy
            assign ready = 1'b1;
        end
    endgenerate

    // Gate the strobe: a write is committed only when idle and unlocked.
    always_comb commit = wr_valid && !key_sel && ready && unlocked;

    // Present the forwarded write and the two status bits.
    always_comb begin
        fwd_we      = commit;
        fwd_addr    = wr_addr;
        fwd_data    = wr_data;
        wr_ready    = ready;
        wr_unlocked = unlocked;
    end

    assert_dropped_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !fwd_we && wr_ready) |=> wr_ready);
endmodule

// File: tb/rtc_write_gate_tb.sv
`timescale 1ns/1ps
module rtc_write_gate_tb;
    import rtc_wgate_pkg::*;

    localparam int unsigned TB_BUSY = 6;
    localparam logic [5:0]  KOFS    = 6'h3C;

    typedef struct {
        logic [5:0]  addr;
        logic [31:0] data;
        bit          fwd;
        bit          chk_open;
        bit          open_fwd;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        fwd_we, wr_ready, wr_unlocked;
    logic [5:0]  fwd_addr;
    logic [31:0] fwd_data;
    logic        o_fwd_we, o_ready, o_unlocked;
    logic [5:0]  o_fwd_addr;
    logic [31:0] o_fwd_data;

    int    n_chk = 0;
    int    n_bad = 0;
    int    n_push = 0;
    int    n_pop = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    rtc_write_gate #(.BUSY_CYC(TB_BUSY), .MODE(GATE_KEYED)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .fwd_we(fwd_we), .fwd_addr(fwd_addr),
        .fwd_data(fwd_data), .wr_ready(wr_ready), .wr_unlocked(wr_unlocked));

    rtc_write_gate #(.BUSY_CYC(TB_BUSY), .MODE(GATE_READY_ONLY)) u_open (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .fwd_we(o_fwd_we), .fwd_addr(o_fwd_addr),
        .fwd_data(o_fwd_data), .wr_ready(o_ready), .wr_unlocked(o_unlocked));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: one write per call, expected outcome pushed to the scoreboard.
    task automatic do_write(input logic [5:0] a, input logic [31:0] d, input bit fwd,
                            input bit chk_open, input bit open_fwd, input string req);
        item_t it;
        it.addr = a; it.data = d; it.fwd = fwd;
        it.chk_open = chk_open; it.open_fwd = open_fwd; it.req = req;
        @(negedge clk);
        sb.push_back(it);
        n_push++;
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Monitor: compares the strobe seen during each write with the scoreboard.
    always begin
        @(negedge clk);
        #1;
        if (wr_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4", "unexpected write", 32'(fwd_we), 32'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                n_pop++;
                chk(fwd_we == it.fwd, it.req, "strobe", 32'(fwd_we), 32'(it.fwd));
                if (it.fwd) begin
                    chk(fwd_addr == it.addr, "R4", "fwd addr", 32'(fwd_addr), 32'(it.addr));
                    chk(fwd_data == it.data, "R4", "fwd data", fwd_data, it.data);
                end
                if (it.chk_open) begin
                    chk(o_fwd_we == it.open_fwd, "R8", "open strobe",
                        32'(o_fwd_we), 32'(it.open_fwd));
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(wr_ready == 1'b1, "R1", "ready", 32'(wr_ready), 32'h1);
        chk(wr_unlocked == 1'b0, "R1", "unlocked", 32'(wr_unlocked), 32'h0);
        chk(fwd_we == 1'b0, "R1", "strobe", 32'(fwd_we), 32'h0);
        chk(o_unlocked == 1'b1, "R8", "open unlocked", 32'(o_unlocked), 32'h1);

        // R7/R8: locked write dropped by the keyed build, passed by the open one
        do_write(6'h04, 32'h0000_0011, 1'b0, 1'b1, 1'b1, "R7");
        chk(wr_ready == 1'b1, "R7", "ready after dropped", 32'(wr_ready), 32'h1);
        chk(wr_unlocked == 1'b0, "R7", "unlocked after dropped", 32'(wr_unlocked), 32'h0);

        // R3: wrong key leaves lock closed
        do_write(KOFS, 32'h0000_1234, 1'b0, 1'b0, 1'b0, "R3");
        chk(wr_unlocked == 1'b0, "R3", "bad key", 32'(wr_unlocked), 32'h0);

        // R2: right key, upper bits ignored
        do_write(KOFS, 32'hDEAD_A55A, 1'b0, 1'b0, 1'b0, "R2");
        chk(wr_unlocked == 1'b1, "R2", "good key", 32'(wr_unlocked), 32'h1);
        chk(wr_ready == 1'b1, "R2", "key no busy", 32'(wr_ready), 32'h1);

        // R4/R5/R6: forwarded write, lock consumed, busy window starts
        do_write(6'h04, 32'hCAFE_0001, 1'b1, 1'b0, 1'b0, "R4");
        chk(wr_ready == 1'b0, "R6", "busy after commit", 32'(wr_ready), 32'h0);
        chk(wr_unlocked == 1'b0, "R5", "relocked", 32'(wr_unlocked), 32'h0);

        // R2: key accepted during the busy window
        do_write(KOFS, 32'h0000_A55A, 1'b0, 1'b0, 1'b0, "R2");
        chk(wr_unlocked == 1'b1, "R2", "key while busy", 32'(wr_unlocked), 32'h1);
        chk(wr_ready == 1'b0, "R6", "still busy", 32'(wr_ready), 32'h0);

        // R7: unlocked write dropped while busy; lock kept, window not extended
        do_write(6'h08, 32'h0000_0005, 1'b0, 1'b0, 1'b0, "R7");
        chk(wr_unlocked == 1'b1, "R7", "lock kept", 32'(wr_unlocked), 32'h1);
        chk(wr_ready == 1'b0, "R6", "busy cycle 5", 32'(wr_ready), 32'h0);
        idle(1);
        chk(wr_ready == 1'b0, "R6", "busy cycle 6", 32'(wr_ready), 32'h0);
        idle(1);
        chk(wr_ready == 1'b1, "R6", "ready after window", 32'(wr_ready), 32'h1);

        // R4/R5: back-to-back writes, second one locked and busy
        do_write(6'h10, 32'hA0A0_A0A0, 1'b1, 1'b0, 1'b0, "R4");
        do_write(6'h14, 32'h0505_0505, 1'b0, 1'b0, 1'b0, "R7");
        idle(TB_BUSY - 2);
        chk(wr_ready == 1'b1, "R6", "ready again", 32'(wr_ready), 32'h1);
        chk(wr_unlocked == 1'b0, "R5", "locked again", 32'(wr_unlocked), 32'h0);

        // R3: wrong key relocks an open gate, following write dropped
        do_write(KOFS, 32'h0000_A55A, 1'b0, 1'b0, 1'b0, "R2");
        chk(wr_unlocked == 1'b1, "R2", "reopen", 32'(wr_unlocked), 32'h1);
        do_write(KOFS, 32'h0000_5AA5, 1'b0, 1'b0, 1'b0, "R3");
        chk(wr_unlocked == 1'b0, "R3", "relock by bad key", 32'(wr_unlocked), 32'h0);
        do_write(6'h04, 32'h0000_0077, 1'b0, 1'b0, 1'b0, "R7");
        chk(wr_ready == 1'b1, "R7", "ready kept", 32'(wr_ready), 32'h1);

        idle(2);
        chk(n_pop == n_push, "R4", "scoreboard drained", 32'(n_pop), 32'(n_push));
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule